// File: doc/BRIEF.md
# Pixel Clock Divider with Output Polarity Control

This block turns a fast reference clock into the pixel timing of a display panel. A single 32-bit configuration word, written over a simple write strobe and data bus, holds a split divider value, a divide-by-one bypass, polarity controls for the horizontal sync, vertical sync and data-enable lines, an option that inverts the pixel clock so that pixel data changes on the other edge, a clocks-per-line value, and an AC-bias period.

The divided pixel clock comes out as a level and as a one-cycle clock-enable pulse in the reference domain. A new ratio is adopted only when the running period ends, so the output never shows a short pulse. The sync inputs, produced elsewhere, come back through one register stage with their polarity set by the configuration. A frame counter driven by rising edges of the raw vertical sync reverses an AC-bias output after every N+1 frames.

Top module: `pxclk_div`

## Requirements
- R1: After reset the configuration word is all zeros, so the ratio is 2; `pix_ce`, `hs_out`, `vs_out`, `de_out`, `ac_bias` and `line_clks` are 0 while reset is held.
- R2: With bypass clear, `pix_ce` pulses for one reference cycle exactly once every R cycles, where R equals the joined divider value plus 2.
- R3: The divider value joins the high field at bits [31:27] above the low field at bits [4:0], giving a 10-bit value {hi, lo}; the range of R is 2 to 1025.
- R4: With bypass bit 26 set, the divider fields are ignored: `pix_ce` is high on every cycle and `pix_clk` follows the reference clock.
- R5: With no clock inversion, `pix_clk` is high for floor(R/2) of the R cycles of each period, starting in the cycle after a `pix_ce` pulse.
- R6: A write that changes the ratio takes effect at the next `pix_ce` pulse; the period in progress completes with the old ratio.
- R7: `hs_out`, `vs_out` and `de_out` equal `hs_in`, `vs_in`, `de_in` one cycle earlier, each XOR-ed with its inversion bit: bit 12 for hsync, bit 11 for vsync, bit 14 for data-enable.
- R8: Bit 13 inverts `pix_clk` (from the next period on), so it is high for R - floor(R/2) cycles of each period.
- R9: `line_clks` shows bits [25:16] of the last word written, from the cycle after the write.
- R10: Bits [10:6] hold N; `ac_bias` reverses on every (N+1)-th rising edge of the raw `vs_in` counted since the last write, so N = 31 gives the longest period; a write restarts the count without reversing `ac_bias`.
- R11: While `reg_wr` is low, changes on `reg_wdata` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the configuration word |
| reg_wdata | input | 32 | Configuration word |
| hs_in | input | 1 | Horizontal sync from the timing generator |
| vs_in | input | 1 | Vertical sync from the timing generator, active high |
| de_in | input | 1 | Data-enable from the timing generator |
| pix_clk | output | 1 | Divided pixel clock level |
| pix_ce | output | 1 | One-cycle pulse at the end of each pixel period |
| hs_out | output | 1 | Horizontal sync with selected polarity |
| vs_out | output | 1 | Vertical sync with selected polarity |
| de_out | output | 1 | Data-enable with selected polarity |
| ac_bias | output | 1 | AC-bias reversal signal |
| line_clks | output | 10 | Stored clocks-per-line value |

## Verification
A wrong period counter or a ratio latched at the wrong moment shows at `pix_ce` within one pixel period as an interval of the wrong length, and a wrong phase threshold shows as a wrong count of high samples of `pix_clk` over that same period, so the bench compares both for every period it tracks. A ratio taken up mid-period is exposed by the first period after the write, which must keep the old length. A wrong frame count shows on `ac_bias` only after N+1 frames, so the longest setting is run through its full 32 frames.

// File: rtl/pxclk_pkg.sv
package pxclk_pkg;
   localparam int REG_W        = 32;
   localparam int POS_ACB      = 6;
   localparam int BIT_INV_VS   = 11;
   localparam int BIT_INV_HS   = 12;
   localparam int BIT_INV_PCLK = 13;
   localparam int BIT_INV_DE   = 14;
   localparam int POS_CPL      = 16;

   typedef enum int {
      SYNC_HS = 0,
      SYNC_VS = 1,
      SYNC_DE = 2
   } sync_idx_e;
   localparam int NUM_SYNC = 3;

   function automatic int sync_inv_bit(input int idx);
      case (idx)
         SYNC_HS: return BIT_INV_HS;
         SYNC_VS: return BIT_INV_VS;
         default: return BIT_INV_DE;
      endcase
   endfunction
endpackage

// File: rtl/pxclk_cfg_reg.sv
module pxclk_cfg_reg
   import pxclk_pkg::*;
#(
   parameter int DIV_LO_W  = 5,
   parameter int DIV_HI_W  = 5,
   parameter int ACB_W     = 5,
   parameter int CPL_W     = 10,
   parameter bit BYPASS_EN = 1'b1,
   localparam int DIV_W    = DIV_LO_W + DIV_HI_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [DIV_W-1:0]     div_val,
   output logic                 bypass,
   output logic [NUM_SYNC-1:0]  inv_sync,
   output logic                 inv_pclk,
   output logic [ACB_W-1:0]     acb_n,
   output logic [CPL_W-1:0]     cpl
);
   localparam int POS_HI  = REG_W - DIV_HI_W;
   localparam int POS_BYP = POS_HI - 1;

   if (DIV_LO_W < 1 || DIV_LO_W > POS_ACB) begin : g_chk_lo
      $error("pxclk_cfg_reg: low divider field overlaps the AC-bias field");
   end
   if (ACB_W < 1 || POS_ACB + ACB_W > BIT_INV_VS) begin : g_chk_acb
      $error("pxclk_cfg_reg: AC-bias field overlaps the inversion bits");
   end
   if (CPL_W < 1 || POS_CPL + CPL_W > POS_BYP) begin : g_chk_cpl
      $error("pxclk_cfg_reg: clocks-per-line field overlaps the bypass bit");
   end

   logic [DIV_LO_W-1:0] lo_q;
   logic [DIV_HI_W-1:0] hi_q;
   logic                ipc_q;
   logic [ACB_W-1:0]    acb_q;
   logic [CPL_W-1:0]    cpl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q  <= '0;
         hi_q  <= '0;
         ipc_q <= 1'b0;
         acb_q <= '0;
         cpl_q <= '0;
      end else if (reg_wr) begin
         lo_q  <= reg_wdata[DIV_LO_W-1:0];
         hi_q  <= reg_wdata[POS_HI +: DIV_HI_W];
         ipc_q <= reg_wdata[BIT_INV_PCLK];
         acb_q <= reg_wdata[POS_ACB +: ACB_W];
         cpl_q <= reg_wdata[POS_CPL +: CPL_W];
      end
   end

   for (genvar i = 0; i < NUM_SYNC; i++) begin : g_inv
      logic inv_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      inv_q <= 1'b0;
         else if (reg_wr) inv_q <= reg_wdata[sync_inv_bit(i)];
      end
      assign inv_sync[i] = inv_q;
   end

   if (BYPASS_EN) begin : g_byp
      logic byp_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      byp_q <= 1'b0;
         else if (reg_wr) byp_q <= reg_wdata[POS_BYP];
      end
      assign bypass = byp_q;
   end else begin : g_no_byp
      assign bypass = 1'b0;
   end

   assign div_val  = {hi_q, lo_q};
   assign inv_pclk = ipc_q;
   assign acb_n    = acb_q;
   assign cpl      = cpl_q;
endmodule

// File: rtl/pxclk_divider.sv
module pxclk_divider #(
   parameter int DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             cfg_bypass,
   input  logic             cfg_inv_pclk,
   output logic             pix_clk,
   output logic             pix_ce,
   output logic             act_bypass
);
   localparam int CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] last_q, last_d;
   logic [CNT_W-1:0] half_q, half_d;
   logic [CNT_W-1:0] ratio_m1, half_new;
   logic             byp_q, inv_q, phase_q, wrap;

   assign wrap     = (cnt_q == last_q);
   assign ratio_m1 = {1'b0, cfg_div} + CNT_W'(1);
   assign half_new = ({1'b0, cfg_div} + CNT_W'(2)) >> 1;

   always_comb begin
      if (wrap) begin
         cnt_d  = '0;
         last_d = cfg_bypass ? '0 : ratio_m1;
         half_d = cfg_bypass ? '0 : half_new;
      end else begin
         cnt_d  = cnt_q + CNT_W'(1);
         last_d = last_q;
         half_d = half_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         last_q  <= CNT_W'(1);
         half_q  <= CNT_W'(1);
         phase_q <= 1'b1;
         byp_q   <= 1'b0;
         inv_q   <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         last_q  <= last_d;
         half_q  <= half_d;
         phase_q <= (cnt_d < half_d);
         if (wrap) begin
            byp_q <= cfg_bypass;
            inv_q <= cfg_inv_pclk;
         end
      end
   end

   assign pix_ce     = wrap;
   assign act_bypass = byp_q;
   assign pix_clk    = (byp_q ? clk : phase_q) ^ inv_q;
endmodule

// File: rtl/pxclk_polarity.sv
module pxclk_polarity #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig_in,
   input  logic [N-1:0] inv,
   output logic [N-1:0] sig_out
);
   for (genvar i = 0; i < N; i++) begin : g_sig
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= sig_in[i] ^ inv[i];
      end
      assign sig_out[i] = q;
   end
endmodule

// File: rtl/pxclk_acbias.sv
module pxclk_acbias #(
   parameter int ACB_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vs_raw,
   input  logic             restart,
   input  logic [ACB_W-1:0] acb_n,
   output logic             frame_tick,
   output logic             ac_bias
);
   logic             vs_d;
   logic [ACB_W-1:0] frm_q;
   logic             ac_q;

   assign frame_tick = vs_raw & ~vs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_d  <= 1'b0;
         frm_q <= '0;
         ac_q  <= 1'b0;
      end else begin
         vs_d <= vs_raw;
         if (restart) begin
            frm_q <= '0;
         end else if (frame_tick) begin
            if (frm_q >= acb_n) begin
               frm_q <= '0;
               ac_q  <= ~ac_q;
            end else begin
               frm_q <= frm_q + ACB_W'(1);
            end
         end
      end
   end

   assign ac_bias = ac_q;
endmodule

// File: rtl/pxclk_div.sv
module pxclk_div
   import pxclk_pkg::*;
#(
   parameter int DIV_LO_W  = 5,
   parameter int DIV_HI_W  = 5,
   parameter int ACB_W     = 5,
   parameter int CPL_W     = 10,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [31:0]      reg_wdata,
   input  logic             hs_in,
   input  logic             vs_in,
   input  logic             de_in,
   output logic             pix_clk,
   output logic             pix_ce,
   output logic             hs_out,
   output logic             vs_out,
   output logic             de_out,
   output logic             ac_bias,
   output logic [CPL_W-1:0] line_clks
);
   localparam int DIV_W = DIV_LO_W + DIV_HI_W;

   logic [DIV_W-1:0]    div_val;
   logic                bypass, inv_pclk, act_bypass, frame_tick;
   logic [NUM_SYNC-1:0] inv_sync, sync_in, sync_out;
   logic [ACB_W-1:0]    acb_n;

   pxclk_cfg_reg #(
      .DIV_LO_W (DIV_LO_W),
      .DIV_HI_W (DIV_HI_W),
      .ACB_W    (ACB_W),
      .CPL_W    (CPL_W),
      .BYPASS_EN(BYPASS_EN)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_wdata(reg_wdata),
      .div_val  (div_val),
      .bypass   (bypass),
      .inv_sync (inv_sync),
      .inv_pclk (inv_pclk),
      .acb_n    (acb_n),
      .cpl      (line_clks)
   );

   pxclk_divider #(.DIV_W(DIV_W)) u_div (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_div     (div_val),
      .cfg_bypass  (bypass),
      .cfg_inv_pclk(inv_pclk),
      .pix_clk     (pix_clk),
      .pix_ce      (pix_ce),
      .act_bypass  (act_bypass)
   );

   assign sync_in[SYNC_HS] = hs_in;
   assign sync_in[SYNC_VS] = vs_in;
   assign sync_in[SYNC_DE] = de_in;

   pxclk_polarity #(.N(NUM_SYNC)) u_pol (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in (sync_in),
      .inv    (inv_sync),
      .sig_out(sync_out)
   );

   assign hs_out = sync_out[SYNC_HS];
   assign vs_out = sync_out[SYNC_VS];
   assign de_out = sync_out[SYNC_DE];

   pxclk_acbias #(.ACB_W(ACB_W)) u_acb (
      .clk       (clk),
      .rst_n     (rst_n),
      .vs_raw    (vs_in),
      .restart   (reg_wr),
      .acb_n     (acb_n),
      .frame_tick(frame_tick),
      .ac_bias   (ac_bias)
   );
endmodule

// File: rtl/pxclk_div_chk.sv
module pxclk_div_chk #(
   parameter int CPL_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [31:0]      reg_wdata,
   input logic             hs_in,
   input logic             vs_in,
   input logic             de_in,
   input logic             pix_ce,
   input logic             hs_out,
   input logic             vs_out,
   input logic             de_out,
   input logic             ac_bias,
   input logic [CPL_W-1:0] line_clks,
   input logic             act_bypass,
   input logic             frame_tick,
   input logic [2:0]       inv_sync
);
   // R4: bypass active means an enable on every cycle
   p_bypass_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
      act_bypass |-> pix_ce);

   // R2: a divided period lasts at least two cycles
   p_ce_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_ce && !act_bypass) |=> (!pix_ce || act_bypass));

   // R7: polarity-corrected sync one cycle later
   p_hs_pol_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (hs_out == ($past(hs_in) ^ $past(inv_sync[0]))));
   p_vs_pol_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (vs_out == ($past(vs_in) ^ $past(inv_sync[1]))));
   p_de_pol_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (de_out == ($past(de_in) ^ $past(inv_sync[2]))));

   // R9: clocks-per-line follows the written word
   p_cpl_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(reg_wr)) |-> (line_clks == $past(reg_wdata[16 +: CPL_W])));

   // R11: no write, no change
   p_cpl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(reg_wr)) |-> $stable(line_clks));

   // R10: the AC-bias output only moves after a frame edge
   p_acb_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ac_bias) |-> $past(frame_tick));
endmodule

bind pxclk_div pxclk_div_chk #(.CPL_W(CPL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .hs_in     (hs_in),
   .vs_in     (vs_in),
   .de_in     (de_in),
   .pix_ce    (pix_ce),
   .hs_out    (hs_out),
   .vs_out    (vs_out),
   .de_out    (de_out),
   .ac_bias   (ac_bias),
   .line_clks (line_clks),
   .act_bypass(act_bypass),
   .frame_tick(frame_tick),
   .inv_sync  (inv_sync)
);

// File: tb/pxclk_div_tb.sv
`timescale 1ns/1ps
module pxclk_div_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        hs_in = 1'b0, vs_in = 1'b0, de_in = 1'b0;
   logic        pix_clk, pix_ce, hs_out, vs_out, de_out, ac_bias;
   logic [9:0]  line_clks;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pxclk_div u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
      .pix_clk(pix_clk), .pix_ce(pix_ce), .hs_out(hs_out), .vs_out(vs_out),
      .de_out(de_out), .ac_bias(ac_bias), .line_clks(line_clks)
   );

   typedef struct {
      int    period;
      int    highs;
      string tag;
   } item_t;
   item_t exp_q[$];

   task automatic check(input string req, input bit ok, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int lo, input int hi, input bit byp,
                                      input bit ihs, input bit ivs, input bit ide,
                                      input bit ipc, input int acb, input int cpl);
      logic [31:0] w;
      w = '0;
      w[4:0]   = lo[4:0];
      w[10:6]  = acb[4:0];
      w[11]    = ivs;
      w[12]    = ihs;
      w[13]    = ipc;
      w[14]    = ide;
      w[25:16] = cpl[9:0];
      w[26]    = byp;
      w[31:27] = hi[4:0];
      return w;
   endfunction

   // monitor: measures each pixel period and pops the expectation
   int  gap = 0;
   int  hi_cnt = 0;
   bit  have_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         gap++;
         if (pix_clk) hi_cnt++;
         if (pix_ce) begin
            if (have_prev && exp_q.size() > 0) begin
               item_t it;
               it = exp_q.pop_front();
               check({it.tag, " period"}, gap == it.period, gap, it.period);
               check({it.tag, " high cycles"}, hi_cnt == it.highs, hi_cnt, it.highs);
            end
            gap = 0;
            hi_cnt = 0;
            have_prev = 1'b1;
         end
      end
   end

   task automatic push(input int period, input int highs, input string tag, input int n);
      for (int i = 0; i < n; i++) begin
         item_t it;
         it.period = period;
         it.highs  = highs;
         it.tag    = tag;
         exp_q.push_back(it);
      end
   endtask

   task automatic write_cfg(input logic [31:0] w);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_wdata = w;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wait_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         do @(negedge clk); while (!pix_ce);
      end
   endtask

   task automatic drain();
      while (exp_q.size() > 0) @(negedge clk);
   endtask

   task automatic run_ratio(input logic [31:0] w, input int r, input int highs,
                            input string tag, input int n);
      write_cfg(w);
      wait_pulses(3);
      @(posedge clk);
      push(r, highs, tag, n);
      drain();
   endtask

   task automatic frame();
      @(negedge clk);
      vs_in = 1'b1;
      @(negedge clk);
      vs_in = 1'b0;
   endtask

   initial begin
      logic exp_ac;
      logic [9:0] cpl_hold;
      repeat (4) @(negedge clk);
      // R1: reset state
      check("R1 pix_ce in reset", pix_ce == 1'b0, pix_ce, 0);
      check("R1 syncs in reset", {hs_out, vs_out, de_out} == 3'b000, {hs_out, vs_out, de_out}, 0);
      check("R1 ac_bias in reset", ac_bias == 1'b0, ac_bias, 0);
      check("R1 line_clks in reset", line_clks == 10'd0, line_clks, 0);
      rst_n = 1'b1;
      wait_pulses(2);
      @(posedge clk);
      push(2, 1, "R1 default ratio", 2);
      drain();

      // R2 R5: small ratios, duty
      run_ratio(mk(1, 0, 0, 0, 0, 0, 0, 0, 0), 3, 1, "R2 R5 lo=1", 3);
      run_ratio(mk(2, 0, 0, 0, 0, 0, 0, 0, 0), 4, 2, "R2 R5 lo=2", 3);
      run_ratio(mk(5, 0, 0, 0, 0, 0, 0, 0, 0), 7, 3, "R2 R5 lo=5", 3);
      // R3: field join
      run_ratio(mk(0, 1, 0, 0, 0, 0, 0, 0, 0), 34, 17, "R3 hi=1 lo=0", 2);
      run_ratio(mk(31, 31, 0, 0, 0, 0, 0, 0, 0), 1025, 512, "R3 max", 2);

      // R4: bypass ignores divider fields
      run_ratio(mk(7, 3, 1, 0, 0, 0, 0, 0, 0), 1, 0, "R4 bypass", 5);
      @(negedge clk);
      check("R4 pix_clk low with clk low", pix_clk == 1'b0, pix_clk, 0);
      @(posedge clk); #1;
      check("R4 pix_clk high with clk high", pix_clk == 1'b1, pix_clk, 1);
      check("R4 pix_ce constant", pix_ce == 1'b1, pix_ce, 1);

      // R6: change takes effect at the next wrap
      run_ratio(mk(3, 0, 0, 0, 0, 0, 0, 0, 0), 5, 2, "R6 old ratio", 2);
      do @(negedge clk); while (!pix_ce);
      @(posedge clk);
      @(negedge clk);
      push(5, 2, "R6 period in progress", 1);
      push(9, 4, "R6 new ratio", 2);
      reg_wr = 1'b1;
      reg_wdata = mk(7, 0, 0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      reg_wr = 1'b0;
      drain();

      // R8: inverted pixel clock
      run_ratio(mk(3, 0, 0, 0, 0, 0, 1, 0, 7), 5, 3, "R8 inverted", 3);

      // R11: data without strobe is ignored
      cpl_hold = line_clks;
      @(negedge clk);
      reg_wdata = mk(0, 0, 1, 1, 1, 1, 0, 0, 1023);
      repeat (20) @(negedge clk);
      check("R11 line_clks held", line_clks == cpl_hold, line_clks, cpl_hold);
      @(posedge clk);
      push(5, 3, "R11 ratio held", 2);
      drain();
      hs_in = 1'b1; vs_in = 1'b0; de_in = 1'b1;
      @(negedge clk);
      check("R11 polarity held", {hs_out, vs_out, de_out} == 3'b101, {hs_out, vs_out, de_out}, 3'b101);
      hs_in = 1'b0; de_in = 1'b0;

      // R7: polarity controls
      write_cfg(mk(3, 0, 0, 1, 0, 1, 0, 0, 0));
      for (int i = 0; i < 8; i++) begin
         logic [2:0] v;
         v = 3'(i);
         hs_in = v[2]; vs_in = v[1]; de_in = v[0];
         @(negedge clk);
         check("R7 hs/vs/de with hs,de inverted", {hs_out, vs_out, de_out} == (v ^ 3'b101),
               {hs_out, vs_out, de_out}, v ^ 3'b101);
      end
      write_cfg(mk(3, 0, 0, 0, 1, 0, 0, 0, 0));
      for (int i = 0; i < 4; i++) begin
         logic [2:0] v;
         v = 3'(i * 3);
         hs_in = v[2]; vs_in = v[1]; de_in = v[0];
         @(negedge clk);
         check("R7 hs/vs/de with vs inverted", {hs_out, vs_out, de_out} == (v ^ 3'b010),
               {hs_out, vs_out, de_out}, v ^ 3'b010);
      end
      hs_in = 1'b0; vs_in = 1'b0; de_in = 1'b0;

      // R9: clocks-per-line
      write_cfg(mk(3, 0, 0, 0, 0, 0, 0, 0, 639));
      check("R9 line_clks 639", line_clks == 10'd639, line_clks, 639);
      write_cfg(mk(3, 0, 0, 0, 0, 0, 0, 0, 1023));
      check("R9 line_clks 1023", line_clks == 10'd1023, line_clks, 1023);

      // R10: AC-bias toggle every N+1 frames
      exp_ac = ac_bias;
      write_cfg(mk(3, 0, 0, 0, 0, 0, 0, 2, 0));
      check("R10 write does not toggle", ac_bias == exp_ac, ac_bias, exp_ac);
      frame(); frame();
      check("R10 N=2 no toggle after 2 frames", ac_bias == exp_ac, ac_bias, exp_ac);
      frame();
      exp_ac = ~exp_ac;
      check("R10 N=2 toggle on frame 3", ac_bias == exp_ac, ac_bias, exp_ac);
      write_cfg(mk(3, 0, 0, 0, 0, 0, 0, 0, 0));
      for (int i = 0; i < 2; i++) begin
         frame();
         exp_ac = ~exp_ac;
         check("R10 N=0 toggle every frame", ac_bias == exp_ac, ac_bias, exp_ac);
      end
      write_cfg(mk(3, 0, 0, 0, 0, 0, 0, 31, 0));
      for (int i = 0; i < 31; i++) frame();
      check("R10 N=31 no toggle after 31 frames", ac_bias == exp_ac, ac_bias, exp_ac);
      frame();
      exp_ac = ~exp_ac;
      check("R10 N=31 toggle on frame 32", ac_bias == exp_ac, ac_bias, exp_ac);

      repeat (4) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule